// File: doc/BRIEF.md
# Fetch Address Patch Unit

This unit sits between instruction memory and the processor's fetch port. It holds a small bank of address slots. Each slot has an enable, a word address and a 32-bit replacement word. When the current fetch address matches an enabled slot and the unit is armed, the returned instruction word is the slot's replacement word instead of the memory data. Substitution is combinational, so a patched fetch costs no extra cycle.

Slots are programmed through a single-cycle write port. Two synchronous reset inputs clear the unit's state in different ways. A power-on reset wipes every setting. A warm reset keeps all slot settings and only disarms the unit.

A protection input reflects active flash readout protection. While it is high, configuration writes are dropped. The fetch of the boot vector word is also never substituted, so the patch bank cannot redirect boot. Fetches at other addresses are still patched.

Top module: `fetch_patch_unit`

## Requirements
- R1: When the unit is armed and an enabled slot's address matches the fetch address, `fetch_rdata` equals that slot's replacement word and `patch_hit` is 1 in the same cycle, with no register in between.
- R2: Matching uses fetch address bits [31:2] only. Bits [1:0] of the fetch address have no effect on a match.
- R3: If several enabled slots match, the lowest-numbered slot supplies the replacement word.
- R4: With no match, a disabled slot or the unit disarmed, `fetch_rdata` equals `mem_rdata` and `patch_hit` is 0.
- R5: While `prot_active` is 1, writes on the configuration port change no setting.
- R6: While `prot_active` is 1, a fetch from word address 0x00000004 is never substituted. Without protection that address is patched like any other.
- R7: Power-on reset (`rst_por`, synchronous, active high) disarms the unit and clears every slot's enable, address and replacement word to zero.
- R8: Warm reset (`rst_warm`, synchronous, active high) disarms the unit and keeps every slot's enable, address and replacement word. A write in a warm reset cycle is dropped.
- R9: The configuration map works as follows. `cfg_addr[3:1]` selects a slot, 0 to 5, and `cfg_addr[0]` selects the register. Register 0 holds enable in bit 0 and address in bits [31:2]. Register 1 holds the replacement word. Slot code 6 with `cfg_addr[0]`=0 is the control word, where bit 0 arms the unit. All other codes are ignored. A write takes effect at the next rising edge.
- R10: `patch_idx` gives the number of the slot supplying the word while `patch_hit` is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por | input | 1 | Power-on reset, synchronous, active high |
| rst_warm | input | 1 | Warm reset, synchronous, active high |
| prot_active | input | 1 | Readout protection active |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| fetch_addr | input | 32 | Current instruction fetch address |
| mem_rdata | input | 32 | Word returned by instruction memory |
| fetch_rdata | output | 32 | Word delivered to the core |
| patch_hit | output | 1 | Current fetch is substituted |
| patch_idx | output | 3 | Slot supplying the substituted word |

## Verification
Two cases are covered where different functions act on the same fetch. In the first, a configuration write hits the very slot that the held fetch address matches. The output must keep the old replacement word during the write cycle and show the new one from the next cycle on. In the second, the boot-guard and a slot match fall on the same boot-vector fetch. Slot 5 is aimed at 0x00000004, and that fetch is checked with and without protection. While protection is high, another slot must still be patched in the same sweep.

// File: rtl/fpatch_pkg.sv
package fpatch_pkg;
  typedef logic [31:0] word_t;
  typedef logic [29:0] waddr_t;
  typedef enum logic {
    SEL_ADDR = 1'b0,
    SEL_REPL = 1'b1
  } reg_sel_e;

  function automatic waddr_t word_of(input word_t a);
    return a[31:2];
  endfunction
endpackage

// File: rtl/fpatch_regs.sv
module fpatch_regs
  import fpatch_pkg::*;
#(
  parameter int NUM    = 6,
  parameter int SLOT_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_por,
  input  logic                   rst_warm,
  input  logic                   wr_en,
  input  logic [SLOT_W-1:0]      wr_slot,
  input  reg_sel_e               wr_sel,
  input  word_t                  wr_data,
  input  logic [SLOT_W-1:0]      rd_idx,
  output logic                   glob_en,
  output logic [NUM-1:0]         slot_en,
  output logic [NUM-1:0][29:0]   slot_addr,
  output word_t                  rd_data
);
  localparam logic [SLOT_W-1:0] CTRL_SLOT = SLOT_W'(NUM);

  logic  wr_ok;
  word_t rep_mem [NUM];

  // writes are dropped in any reset cycle
  assign wr_ok = wr_en && !rst_warm;

  always_ff @(posedge clk) begin
    if (rst_por || rst_warm) begin
      glob_en <= 1'b0;
    end else if (wr_ok && wr_slot == CTRL_SLOT && wr_sel == SEL_ADDR) begin
      glob_en <= wr_data[0];
    end
  end

  for (genvar k = 0; k < NUM; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst_por) begin
        slot_en[k]   <= 1'b0;
        slot_addr[k] <= '0;
      end else if (wr_ok && wr_slot == SLOT_W'(k) && wr_sel == SEL_ADDR) begin
        slot_en[k]   <= wr_data[0];
        slot_addr[k] <= word_of(wr_data);
      end
    end

    always_ff @(posedge clk) begin
      if (rst_por) begin
        rep_mem[k] <= '0;
      end else if (wr_ok && wr_slot == SLOT_W'(k) && wr_sel == SEL_REPL) begin
        rep_mem[k] <= wr_data;
      end
    end
  end

  assign rd_data = rep_mem[rd_idx];
endmodule

// File: rtl/fpatch_match.sv
module fpatch_match
  import fpatch_pkg::*;
#(
  parameter int NUM    = 6,
  parameter int SLOT_W = 3
) (
  input  waddr_t                 fetch_word,
  input  logic [NUM-1:0]         slot_en,
  input  logic [NUM-1:0][29:0]   slot_addr,
  output logic                   any_hit,
  output logic [SLOT_W-1:0]      win_idx
);
  logic [NUM-1:0] hit_vec;

  for (genvar k = 0; k < NUM; k++) begin : g_cmp
    assign hit_vec[k] = slot_en[k] && (slot_addr[k] == fetch_word);
  end

  assign any_hit = |hit_vec;

  // scan downward so the lowest set index is the one left standing
  always_comb begin
    win_idx = '0;
    for (int k = NUM - 1; k >= 0; k--) begin
      if (hit_vec[k]) win_idx = SLOT_W'(k);
    end
  end
endmodule

// File: rtl/fetch_patch_unit.sv
module fetch_patch_unit
  import fpatch_pkg::*;
#(
  parameter int          NUM_SLOTS = 6,
  parameter logic [31:0] BOOT_VEC  = 32'h0000_0004,
  localparam int         SLOT_W    = $clog2(NUM_SLOTS + 1),
  localparam int         CFG_AW    = SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rst_por,
  input  logic              rst_warm,
  input  logic              prot_active,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic [31:0]       fetch_addr,
  input  logic [31:0]       mem_rdata,
  output logic [31:0]       fetch_rdata,
  output logic              patch_hit,
  output logic [SLOT_W-1:0] patch_idx
);
  logic                       glob_en;
  logic [NUM_SLOTS-1:0]       slot_en;
  logic [NUM_SLOTS-1:0][29:0] slot_addr;
  logic                       any_hit;
  logic [SLOT_W-1:0]          win_idx;
  word_t                      rep_word;
  logic                       boot_fetch;
  reg_sel_e                   wr_sel;

  assign wr_sel = reg_sel_e'(cfg_addr[0]);

  fpatch_regs #(.NUM(NUM_SLOTS), .SLOT_W(SLOT_W)) regs_i (
    .clk      (clk),
    .rst_por  (rst_por),
    .rst_warm (rst_warm),
    .wr_en    (cfg_we && !prot_active),
    .wr_slot  (cfg_addr[CFG_AW-1:1]),
    .wr_sel   (wr_sel),
    .wr_data  (cfg_wdata),
    .rd_idx   (win_idx),
    .glob_en  (glob_en),
    .slot_en  (slot_en),
    .slot_addr(slot_addr),
    .rd_data  (rep_word)
  );

  fpatch_match #(.NUM(NUM_SLOTS), .SLOT_W(SLOT_W)) match_i (
    .fetch_word(word_of(fetch_addr)),
    .slot_en   (slot_en),
    .slot_addr (slot_addr),
    .any_hit   (any_hit),
    .win_idx   (win_idx)
  );

  assign boot_fetch  = word_of(fetch_addr) == word_of(BOOT_VEC);
  assign patch_hit   = glob_en && any_hit && !(prot_active && boot_fetch);
  assign patch_idx   = patch_hit ? win_idx : '0;
  assign fetch_rdata = patch_hit ? rep_word : mem_rdata;
endmodule

// File: rtl/fpatch_chk.sv
module fpatch_chk #(
  parameter int          NUM    = 6,
  parameter int          SLOT_W = 3,
  parameter logic [31:0] BOOT   = 32'h4
) (
  input logic              clk,
  input logic              rst_por,
  input logic              rst_warm,
  input logic              prot_active,
  input logic              cfg_we,
  input logic [31:0]       fetch_addr,
  input logic [31:0]       mem_rdata,
  input logic [31:0]       fetch_rdata,
  input logic              patch_hit,
  input logic [SLOT_W-1:0] patch_idx,
  input logic              glob_en,
  input logic [NUM-1:0]    slot_en
);
  p_passthru_r4: assert property (@(posedge clk) disable iff (rst_por || rst_warm)
    !patch_hit |-> fetch_rdata == mem_rdata);

  p_disarmed_r4: assert property (@(posedge clk) disable iff (rst_por || rst_warm)
    !glob_en |-> !patch_hit);

  p_boot_guard_r6: assert property (@(posedge clk) disable iff (rst_por || rst_warm)
    (prot_active && fetch_addr[31:2] == BOOT[31:2]) |-> (!patch_hit && fetch_rdata == mem_rdata));

  p_locked_r5: assert property (@(posedge clk) disable iff (rst_por || rst_warm)
    (prot_active && cfg_we) |=> ($stable(slot_en) && $stable(glob_en)));

  p_por_clear_r7: assert property (@(posedge clk) disable iff (rst_warm)
    rst_por |=> (!glob_en && slot_en == '0));

  p_warm_keep_r8: assert property (@(posedge clk) disable iff (rst_por)
    rst_warm |=> (!glob_en && $stable(slot_en)));

  p_idx_idle_r10: assert property (@(posedge clk) disable iff (rst_por || rst_warm)
    !patch_hit |-> patch_idx == '0);
endmodule

bind fetch_patch_unit fpatch_chk #(.NUM(NUM_SLOTS), .SLOT_W(SLOT_W), .BOOT(BOOT_VEC)) chk_i (
  .clk        (clk),
  .rst_por    (rst_por),
  .rst_warm   (rst_warm),
  .prot_active(prot_active),
  .cfg_we     (cfg_we),
  .fetch_addr (fetch_addr),
  .mem_rdata  (mem_rdata),
  .fetch_rdata(fetch_rdata),
  .patch_hit  (patch_hit),
  .patch_idx  (patch_idx),
  .glob_en    (glob_en),
  .slot_en    (slot_en)
);

// File: tb/fetch_patch_unit_tb_top.sv
`timescale 1ns/1ps
module fetch_patch_unit_tb_top;
  localparam int NS = 6;

  logic        clk = 1'b0;
  logic        rst_por = 1'b1;
  logic        rst_warm = 1'b0;
  logic        prot_active = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] fetch_addr = '0;
  logic [31:0] mem_rdata = '0;
  logic [31:0] fetch_rdata;
  logic        patch_hit;
  logic [2:0]  patch_idx;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic        m_glob;
  logic        m_en   [NS];
  logic [29:0] m_addr [NS];
  logic [31:0] m_rep  [NS];

  always #2.5 clk = ~clk;

  fetch_patch_unit dut_i (
    .clk(clk), .rst_por(rst_por), .rst_warm(rst_warm), .prot_active(prot_active),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .fetch_addr(fetch_addr), .mem_rdata(mem_rdata),
    .fetch_rdata(fetch_rdata), .patch_hit(patch_hit), .patch_idx(patch_idx)
  );

  function automatic logic [31:0] mem_of(input logic [31:0] a);
    return ~a ^ 32'h5A5A_0000;
  endfunction

  task automatic model_clear();
    m_glob = 1'b0;
    for (int k = 0; k < NS; k++) begin
      m_en[k] = 1'b0; m_addr[k] = '0; m_rep[k] = '0;
    end
  endtask

  // compare outputs against the model for the inputs now applied
  task automatic check_now(input string tag);
    logic [31:0] e_data;
    logic        e_hit;
    logic [2:0]  e_idx;
    bit          found;
    found = 1'b0; e_idx = '0;
    for (int k = 0; k < NS; k++) begin
      if (!found && m_en[k] && m_addr[k] == fetch_addr[31:2]) begin
        found = 1'b1; e_idx = 3'(k);
      end
    end
    e_hit  = m_glob && found && !(prot_active && fetch_addr[31:2] == 30'd1);
    if (!e_hit) e_idx = '0;
    e_data = e_hit ? m_rep[e_idx] : mem_rdata;
    n_tests++;
    if (fetch_rdata !== e_data || patch_hit !== e_hit || patch_idx !== e_idx) begin
      n_fail++;
      $display("FAIL %s addr=%h: data=%h hit=%b idx=%0d expected data=%h hit=%b idx=%0d",
               tag, fetch_addr, fetch_rdata, patch_hit, patch_idx, e_data, e_hit, e_idx);
    end
  endtask

  task automatic fetch(input logic [31:0] a, input string tag);
    @(negedge clk);
    fetch_addr = a;
    mem_rdata  = mem_of(a);
    #1;
    check_now(tag);
  endtask

  // write; the held fetch must still see old settings in the write cycle
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    #1;
    check_now("R9 old value during write cycle");
    @(negedge clk);
    cfg_we = 1'b0;
    if (!prot_active) begin
      if (a[3:1] < 3'(NS)) begin
        if (!a[0]) begin
          m_en[a[3:1]] = d[0]; m_addr[a[3:1]] = d[31:2];
        end else begin
          m_rep[a[3:1]] = d;
        end
      end else if (a[3:1] == 3'(NS) && !a[0]) begin
        m_glob = d[0];
      end
    end
    #1;
    check_now("R9 new value after write");
  endtask

  task automatic sweep(input string tag);
    logic [31:0] bases [8];
    bases = '{32'h0000_0100, 32'h0800_0040, 32'h0800_1234, 32'hFFFF_FFFC,
              32'h0000_0004, 32'h0000_0000, 32'h2000_0008, 32'h0800_0044};
    for (int b = 0; b < 8; b++) begin
      for (int o = -4; o <= 7; o++) begin
        fetch(bases[b] + 32'(o), tag);
      end
    end
  endtask

  task automatic slot_cfg(input int k, input logic [31:0] a, input logic en, input logic [31:0] r);
    wr({3'(k), 1'b0}, {a[31:2], 1'b0, en});
    wr({3'(k), 1'b1}, r);
  endtask

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_por = 1'b0;
    fetch(32'h0000_0004, "R7 reset state boot vector");
    sweep("R7 reset state passthrough");

    slot_cfg(0, 32'h0000_0100, 1'b1, 32'hC0DE_0000);
    slot_cfg(1, 32'h0800_0040, 1'b1, 32'hC0DE_0001);
    slot_cfg(2, 32'h0800_1234, 1'b1, 32'hC0DE_0002);
    slot_cfg(3, 32'hFFFF_FFFC, 1'b1, 32'hC0DE_0003);
    slot_cfg(4, 32'h0800_1234, 1'b1, 32'hC0DE_0004);
    slot_cfg(5, 32'h0000_0004, 1'b1, 32'hC0DE_0005);
    sweep("R4 disarmed");
    wr(4'b1100, 32'h1);
    sweep("R1 R2 R3 R10 armed sweep");

    // write to the slot the held fetch matches
    @(negedge clk); fetch_addr = 32'h0800_0042; mem_rdata = mem_of(fetch_addr);
    wr(4'b0011, 32'hBEEF_0001);
    wr({3'd2, 1'b0}, {30'h0200_048D, 2'b00});
    sweep("R4 R3 slot 2 disabled");
    wr(4'b1110, 32'hFFFF_FFFF);
    wr(4'b1111, 32'hFFFF_FFFF);
    wr(4'b1101, 32'h0);
    sweep("R9 unused codes ignored");

    prot_active = 1'b1;
    sweep("R6 boot guard under protection");
    wr(4'b0000, 32'h0);
    wr(4'b0001, 32'h1111_1111);
    wr(4'b1100, 32'h0);
    sweep("R5 writes ignored under protection");
    prot_active = 1'b0;
    fetch(32'h0000_0004, "R6 boot vector patched without protection");

    @(negedge clk); rst_warm = 1'b1; cfg_we = 1'b1; cfg_addr = 4'b0001; cfg_wdata = 32'h7777_7777;
    @(negedge clk); rst_warm = 1'b0; cfg_we = 1'b0; m_glob = 1'b0;
    sweep("R8 disarmed after warm reset");
    wr(4'b1100, 32'h1);
    sweep("R8 settings kept after warm reset");

    @(negedge clk); rst_por = 1'b1;
    @(negedge clk); rst_por = 1'b0; model_clear();
    sweep("R7 cleared after power-on reset");
    wr(4'b1100, 32'h1);
    sweep("R7 slots cleared while armed");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule